// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block scans a switch matrix of up to 6 row inputs and 5 column outputs (30 keys). Row inputs are pulled up, so a closed switch pulls its row low only while its column is driven low. While waiting, the scanner drives every column low, so any press pulls at least one active row low. A press must stay present for a programmable debounce interval. The scanner then walks the columns in a programmable slot order. It drives one column low per slot and samples the rows at the end of each slot's hold time.

If exactly one closure is seen over the whole sweep, the column index and row index are latched and a sticky interrupt is raised. Two or more closures discard the press. In both cases the scanner waits until every active row has read high for a full debounce interval before it accepts a new press. The host can also take the columns over directly (bypass) and read the masked row inputs to scan by hand. Unused rows can be masked away with a row-count setting.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, every column output is low, the interrupt is low, the latched column and row are 0, and the row status reads all ones (0x3F) with no key closed.
- R2: While `scan_en` is 0, a closed key never raises the interrupt.
- R3: Between sweeps (waiting for a press, debouncing, waiting for release), all column outputs are driven low, and a low level on any active row starts the debounce.
- R4: A press is accepted only if some active row stays low for (db_time+1) x TICK_CYCLES clocks. If all rows go high earlier, the press is dropped. A clean single press held from before clock edge 1 raises the interrupt at edge 1 + (db_time+1)·TICK_CYCLES + NCOL·(scan_time+1)·SCAN_UNIT.
- R5: During a sweep, slot k (k = 0..NCOL-1) drives low only the column whose index is in `scan_order[3k+2:3k]` and drives every other column high. Each slot lasts (scan_time+1)·SCAN_UNIT clocks. A slot holding an index of NCOL or more drives all columns high but still takes its full time.
- R6: A sweep with exactly one closure latches `key_col` (the column index, 0 = `cols_n_o[0]`) and `key_row` (the row index, 0 = `rows_n_i[0]`) and sets `key_irq`.
- R7: A sweep that sees two or more closures, in the same column or in different columns, leaves `key_irq`, `key_col` and `key_row` unchanged. After all keys are released, a later single press is reported normally.
- R8: `row_cnt` values 1 to 6 make rows 0 to row_cnt-1 active, and 0 or 7 makes all rows active. Inactive rows read 1 in `row_status` and never start or affect a scan.
- R9: After a sweep, no new press is accepted while any active row is low. Re-arming needs all active rows high for one full debounce interval.
- R10: `key_irq` stays set until a one-cycle `irq_clr` pulse clears it. Releasing the key does not clear it.
- R11: While `bypass_en` is 1, `cols_n_o` equals `bypass_col`, `row_status` shows the masked rows, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Enables hardware scanning |
| bypass_en | input | 1 | Host drives the columns directly |
| bypass_col | input | NCOL | Column levels used in bypass |
| db_time | input | 6 | Debounce interval minus one, in ticks |
| scan_time | input | 2 | Slot hold minus one, in scan units |
| row_cnt | input | 3 | Number of active rows (0 or 7 = all) |
| scan_order | input | 3*NCOL | Column index for each sweep slot, 3 bits per slot |
| irq_clr | input | 1 | Clears the interrupt |
| rows_n_i | input | NROW | Row inputs, low = closed |
| cols_n_o | output | NCOL | Column drives, low = selected |
| row_status | output | NROW | Row inputs with inactive rows forced high |
| key_col | output | 3 | Column index of the last valid key |
| key_row | output | $clog2(NROW) | Row index of the last valid key |
| key_irq | output | 1 | Sticky valid-key interrupt |

## Verification
The testbench models the matrix as a set of closed switches: a row reads low when one of its closed keys sits on a column that is driven low. Single keys in different corners, under natural, shuffled and skip-containing scan orders, check the column walk and the latched codes. They also check the exact clock count to the interrupt, which separates a wrong debounce length from a wrong slot length. Short glitches, two keys in one column, and two keys in different columns separate debounce rejection from multi-key rejection. Keys on masked rows, keys held after the interrupt is cleared, and keys pressed under bypass show that each of those paths stays silent.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  localparam int KP_IDX_W = 3;

  typedef enum logic [1:0] {
    KP_IDLE,
    KP_SETTLE,
    KP_SWEEP,
    KP_DRAIN
  } kp_state_e;

  // clocks in one debounce interval
  function automatic int unsigned kp_debounce_len(logic [5:0] db, int unsigned tick);
    return (int'(db) + 1) * tick;
  endfunction

  // clocks that one sweep slot lasts
  function automatic int unsigned kp_slot_len(logic [1:0] st, int unsigned unit);
    return (int'(st) + 1) * unit;
  endfunction

  // active-row mask: 1..nrow rows in use, anything else means all rows
  function automatic logic [31:0] kp_row_enable(logic [2:0] rc, int nrow);
    if (rc == 3'd0 || int'(rc) > nrow)
      return (32'd1 << nrow) - 32'd1;
    return (32'd1 << rc) - 32'd1;
  endfunction

endpackage

// File: rtl/kp_row_mask.sv
module kp_row_mask
  import keypad_pkg::*;
#(
  parameter int NROW = 6
) (
  input  logic [NROW-1:0] rows_n_i,
  input  logic [2:0]      row_cnt,
  output logic [NROW-1:0] rows_eff,
  output logic            any_low
);
  logic [31:0] en_full;

  assign en_full  = kp_row_enable(row_cnt, NROW);
  assign rows_eff = rows_n_i | ~en_full[NROW-1:0];
  assign any_low  = ~&rows_eff;
endmodule

// File: rtl/kp_interval_timer.sv
module kp_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
  import keypad_pkg::*;
#(
  parameter int NROW = 6,
  parameter int NCOL = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  input  logic                      bypass_en,
  input  logic [KP_IDX_W*NCOL-1:0]  scan_order,
  input  logic [NROW-1:0]           rows_eff,
  input  logic                      any_low,
  input  logic                      irq_clr,
  input  logic                      tmr_done,
  output logic                      tmr_clr,
  output logic                      tmr_sel,
  output logic [NCOL-1:0]           col_drive_n,
  output logic [KP_IDX_W-1:0]       key_col,
  output logic [$clog2(NROW)-1:0]   key_row,
  output logic                      key_irq,
  output logic                      key_event
);
  localparam int RW = $clog2(NROW);
  localparam int SW = (NCOL > 1) ? $clog2(NCOL) : 1;

  kp_state_e             st;
  logic [SW-1:0]         slot;
  logic [1:0]            hits;
  logic [1:0]            hits_sum;
  logic [KP_IDX_W-1:0]   cap_col;
  logic [RW-1:0]         cap_row;
  logic [KP_IDX_W-1:0]   idx;
  logic                  idx_ok;
  logic                  last_slot;
  logic                  active;
  int                    smp_cnt;
  logic [RW-1:0]         low_row;

  function automatic logic [RW-1:0] first_low(logic [NROW-1:0] v);
    logic [RW-1:0] r;
    r = '0;
    for (int i = NROW - 1; i >= 0; i--)
      if (!v[i]) r = RW'(i);
    return r;
  endfunction

  assign active    = scan_en && !bypass_en;
  assign idx       = scan_order[int'(slot)*KP_IDX_W +: KP_IDX_W];
  assign idx_ok    = int'(idx) < NCOL;
  assign last_slot = (int'(slot) == NCOL - 1);
  assign smp_cnt   = $countones(~rows_eff);
  assign low_row   = first_low(rows_eff);

  always_comb begin
    int tot;
    tot = int'(hits) + smp_cnt;
    hits_sum = (tot >= 2) ? 2'd2 : tot[1:0];
  end

  assign key_event = active && (st == KP_SWEEP) && tmr_done && last_slot && (hits_sum == 2'd1);
  assign tmr_sel   = (st == KP_SWEEP);
  assign tmr_clr   = !active || (st == KP_IDLE) || tmr_done || ((st == KP_DRAIN) && any_low);

  always_comb begin
    col_drive_n = '0;
    if (st == KP_SWEEP) begin
      col_drive_n = '1;
      for (int c = 0; c < NCOL; c++)
        if (idx_ok && int'(idx) == c) col_drive_n[c] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= KP_IDLE;
      slot    <= '0;
      hits    <= '0;
      cap_col <= '0;
      cap_row <= '0;
      key_col <= '0;
      key_row <= '0;
      key_irq <= 1'b0;
    end else begin
      if (key_event)    key_irq <= 1'b1;
      else if (irq_clr) key_irq <= 1'b0;

      if (key_event) begin
        key_col <= (hits == 2'd0) ? idx : cap_col;
        key_row <= (hits == 2'd0) ? low_row : cap_row;
      end

      if (!active) begin
        st   <= KP_IDLE;
        slot <= '0;
        hits <= '0;
      end else begin
        case (st)
          KP_IDLE:   if (any_low) st <= KP_SETTLE;
          KP_SETTLE: begin
            if (!any_low) st <= KP_IDLE;
            else if (tmr_done) begin
              st   <= KP_SWEEP;
              slot <= '0;
              hits <= '0;
            end
          end
          KP_SWEEP: begin
            if (tmr_done) begin
              hits <= hits_sum;
              if (hits == 2'd0 && smp_cnt == 1) begin
                cap_col <= idx;
                cap_row <= low_row;
              end
              if (last_slot) st <= KP_DRAIN;
              else           slot <= slot + 1'b1;
            end
          end
          default:   if (tmr_done && !any_low) st <= KP_IDLE;
        endcase
      end
    end
  end

  // R5: a sweep slot never selects more than one column
  a_r5_one_column: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KP_SWEEP) |-> ($countones(~col_drive_n) <= 1));

  // R4: a press that vanishes during debounce returns to waiting
  a_r4_settle_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == KP_SETTLE && !any_low) |=> (st == KP_IDLE));

  // R9: a held row keeps the scanner waiting for release
  a_r9_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == KP_DRAIN && any_low) |=> (st == KP_DRAIN));

  // R10: the interrupt only drops on a clear request
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (key_irq && !irq_clr) |=> key_irq);

  // R6: an accepted key always shows up on the interrupt
  a_r6_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |=> key_irq);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_pkg::*;
#(
  parameter int NROW        = 6,
  parameter int NCOL        = 5,
  parameter int TICK_CYCLES = 200000,
  parameter int SCAN_UNIT   = 2000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scan_en,
  input  logic                         bypass_en,
  input  logic [NCOL-1:0]              bypass_col,
  input  logic [5:0]                   db_time,
  input  logic [1:0]                   scan_time,
  input  logic [2:0]                   row_cnt,
  input  logic [KP_IDX_W*NCOL-1:0]     scan_order,
  input  logic                         irq_clr,
  input  logic [NROW-1:0]              rows_n_i,
  output logic [NCOL-1:0]              cols_n_o,
  output logic [NROW-1:0]              row_status,
  output logic [KP_IDX_W-1:0]          key_col,
  output logic [$clog2(NROW)-1:0]      key_row,
  output logic                         key_irq
);
  localparam int CW = $clog2(64 * TICK_CYCLES + 4 * SCAN_UNIT + 1);

  logic [NROW-1:0] rows_eff;
  logic            any_low;
  logic            tmr_clr;
  logic            tmr_sel;
  logic            tmr_done;
  logic [CW-1:0]   tmr_len;
  logic [NCOL-1:0] col_drive_n;
  logic            key_event;

  kp_row_mask #(.NROW(NROW)) mask_i (
    .rows_n_i (rows_n_i),
    .row_cnt  (row_cnt),
    .rows_eff (rows_eff),
    .any_low  (any_low)
  );

  assign tmr_len = tmr_sel ? CW'(kp_slot_len(scan_time, SCAN_UNIT))
                           : CW'(kp_debounce_len(db_time, TICK_CYCLES));

  kp_interval_timer #(.CW(CW)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .len   (tmr_len),
    .done  (tmr_done)
  );

  kp_scan_ctrl #(.NROW(NROW), .NCOL(NCOL)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .bypass_en   (bypass_en),
    .scan_order  (scan_order),
    .rows_eff    (rows_eff),
    .any_low     (any_low),
    .irq_clr     (irq_clr),
    .tmr_done    (tmr_done),
    .tmr_clr     (tmr_clr),
    .tmr_sel     (tmr_sel),
    .col_drive_n (col_drive_n),
    .key_col     (key_col),
    .key_row     (key_row),
    .key_irq     (key_irq),
    .key_event   (key_event)
  );

  assign cols_n_o   = bypass_en ? bypass_col : col_drive_n;
  assign row_status = rows_eff;

  // R11: host-driven columns never produce a key report
  a_r11_bypass_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && $past(bypass_en)) |-> !key_event);

  // R2: a disabled scanner never reports a key
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !key_event);
endmodule

// File: tb/keypad_scanner_tb_top.sv
module keypad_scanner_tb_top;
  localparam int NROW = 6;
  localparam int NCOL = 5;
  localparam int TICK = 8;
  localparam int UNIT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic bypass_en = 1'b0;
  logic [NCOL-1:0] bypass_col = '1;
  logic [5:0] db_time = 6'd2;
  logic [1:0] scan_time = 2'd1;
  logic [2:0] row_cnt = 3'd0;
  logic [3*NCOL-1:0] scan_order;
  logic irq_clr = 1'b0;
  logic [NROW-1:0] rows_n_i;
  logic [NCOL-1:0] cols_n_o;
  logic [NROW-1:0] row_status;
  logic [2:0] key_col;
  logic [2:0] key_row;
  logic key_irq;

  logic [NROW-1:0][NCOL-1:0] pressed = '0;

  int vectors = 0;
  int fails = 0;
  int seq [0:15];
  int seq_n = 0;
  bit rec_en = 1'b0;
  logic [NCOL-1:0] prev_cols = '0;

  always #10 clk = ~clk;

  function automatic logic [3*NCOL-1:0] mk_order(int a, int b, int c, int d, int e);
    logic [3*NCOL-1:0] o;
    o = {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
    return o;
  endfunction

  initial scan_order = mk_order(0, 1, 2, 3, 4);

  always_comb begin
    for (int r = 0; r < NROW; r++)
      rows_n_i[r] = ~|(pressed[r] & ~cols_n_o);
  end

  keypad_scanner #(.NROW(NROW), .NCOL(NCOL), .TICK_CYCLES(TICK), .SCAN_UNIT(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .bypass_en(bypass_en),
    .bypass_col(bypass_col), .db_time(db_time), .scan_time(scan_time),
    .row_cnt(row_cnt), .scan_order(scan_order), .irq_clr(irq_clr),
    .rows_n_i(rows_n_i), .cols_n_o(cols_n_o), .row_status(row_status),
    .key_col(key_col), .key_row(key_row), .key_irq(key_irq)
  );

  // column walk recorder
  always @(negedge clk) begin
    if (rec_en && cols_n_o != prev_cols && $countones(~cols_n_o) == 1) begin
      for (int c = 0; c < NCOL; c++)
        if (!cols_n_o[c] && seq_n < 16) begin
          seq[seq_n] = c;
          seq_n++;
        end
    end
    prev_cols = cols_n_o;
  end

  task automatic expect_eq(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int db_len();
    return (int'(db_time) + 1) * TICK;
  endfunction

  function automatic int latency();
    return 1 + db_len() + NCOL * (int'(scan_time) + 1) * UNIT;
  endfunction

  task automatic wait_irq(int maxc, output int n);
    n = 0;
    while (!key_irq && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
  endtask

  task automatic settle();
    pressed = '0;
    tick(db_len() + 20);
    pulse_clr();
    tick(2);
  endtask

  task automatic t_reset();
    expect_eq("R1 columns low", int'(cols_n_o), 0);
    expect_eq("R1 irq low", int'(key_irq), 0);
    expect_eq("R1 key_col", int'(key_col), 0);
    expect_eq("R1 key_row", int'(key_row), 0);
    expect_eq("R1 row status", int'(row_status), 'h3F);
  endtask

  task automatic t_disabled();
    pressed[2][3] = 1'b1;
    tick(150);
    expect_eq("R2 no irq when disabled", int'(key_irq), 0);
    pressed = '0;
    tick(5);
    scan_en = 1'b1;
    tick(5);
  endtask

  task automatic t_basic();
    int n;
    pressed[3][2] = 1'b1;
    tick(3);
    expect_eq("R3 columns low while debouncing", int'(cols_n_o), 0);
    wait_irq(400, n);
    n += 3;
    expect_eq("R4 press to irq clocks", n, latency());
    expect_eq("R6 key_col", int'(key_col), 2);
    expect_eq("R6 key_row", int'(key_row), 3);
    pressed = '0;
    tick(40);
    expect_eq("R10 irq held after release", int'(key_irq), 1);
    pulse_clr();
    expect_eq("R10 irq cleared", int'(key_irq), 0);
    tick(5);
  endtask

  task automatic t_order(int a, int b, int c, int d, int e, int r, int col, int exp_n);
    int n;
    int exp_seq [0:4];
    exp_seq = '{a, b, c, d, e};
    scan_order = mk_order(a, b, c, d, e);
    scan_time = 2'd0;
    seq_n = 0;
    rec_en = 1'b1;
    pressed[r][col] = 1'b1;
    wait_irq(400, n);
    rec_en = 1'b0;
    expect_eq("R5 latency with order", n, latency());
    expect_eq("R5 slot count", seq_n, exp_n);
    begin
      int k;
      k = 0;
      for (int i = 0; i < 5; i++)
        if (exp_seq[i] < NCOL) begin
          expect_eq("R5 column in slot", (k < seq_n) ? seq[k] : -1, exp_seq[i]);
          k++;
        end
    end
    expect_eq("R6 key_col by order", int'(key_col), col);
    expect_eq("R6 key_row by order", int'(key_row), r);
    settle();
    scan_time = 2'd1;
    scan_order = mk_order(0, 1, 2, 3, 4);
  endtask

  task automatic t_glitch();
    pressed[0][0] = 1'b1;
    tick(10);
    pressed = '0;
    tick(120);
    expect_eq("R4 short press ignored", int'(key_irq), 0);
    expect_eq("R4 key_col kept", int'(key_col), 4);
    expect_eq("R4 key_row kept", int'(key_row), 5);
  endtask

  task automatic t_multi(int r0, int c0, int r1, int c1);
    int n;
    pressed[r0][c0] = 1'b1;
    pressed[r1][c1] = 1'b1;
    wait_irq(200, n);
    expect_eq("R7 multi-key no irq", int'(key_irq), 0);
    expect_eq("R7 key_col kept", int'(key_col), 4);
    expect_eq("R7 key_row kept", int'(key_row), 5);
    settle();
  endtask

  task automatic t_rearm();
    int n;
    pressed[2][1] = 1'b1;
    wait_irq(400, n);
    expect_eq("R7 rearm after multi", n, latency());
    expect_eq("R7 rearm key_col", int'(key_col), 1);
    expect_eq("R7 rearm key_row", int'(key_row), 2);
    settle();
  endtask

  task automatic t_rows();
    int n;
    row_cnt = 3'd3;
    tick(2);
    pressed[4][0] = 1'b1;
    tick(2);
    expect_eq("R8 masked row reads high", int'(row_status), 'h3F);
    wait_irq(200, n);
    expect_eq("R8 masked row no irq", int'(key_irq), 0);
    pressed = '0;
    tick(5);
    pressed[2][0] = 1'b1;
    tick(2);
    expect_eq("R8 active row shows low", int'(row_status), 'h3B);
    wait_irq(400, n);
    n += 2;
    expect_eq("R8 active row latency", n, latency());
    expect_eq("R8 key_row", int'(key_row), 2);
    expect_eq("R8 key_col", int'(key_col), 0);
    row_cnt = 3'd0;
  endtask

  task automatic t_release();
    int n;
    pulse_clr();
    tick(200);
    expect_eq("R9 held key not reported again", int'(key_irq), 0);
    pressed = '0;
    db_time = 6'd0;
    tick(60);
    expect_eq("R9 release alone gives no irq", int'(key_irq), 0);
    pressed[5][4] = 1'b1;
    wait_irq(400, n);
    expect_eq("R4 latency with short debounce", n, latency());
    expect_eq("R9 next key_col", int'(key_col), 4);
    expect_eq("R9 next key_row", int'(key_row), 5);
    settle();
    db_time = 6'd2;
    tick(5);
  endtask

  task automatic t_bypass();
    bypass_en = 1'b1;
    bypass_col = 5'b10110;
    tick(2);
    expect_eq("R11 columns follow host", int'(cols_n_o), 'b10110);
    pressed[0][0] = 1'b1;
    tick(2);
    expect_eq("R11 row status shows closure", int'(row_status), 'h3E);
    tick(200);
    expect_eq("R11 no irq in bypass", int'(key_irq), 0);
    bypass_col = 5'b11111;
    tick(1);
    expect_eq("R11 row status released", int'(row_status), 'h3F);
    pressed = '0;
    bypass_en = 1'b0;
    tick(3);
    expect_eq("R3 columns low after bypass", int'(cols_n_o), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_disabled();
    t_basic();
    t_order(3, 0, 4, 1, 2, 1, 4, 5);
    t_order(0, 7, 1, 2, 4, 5, 4, 4);
    t_glitch();
    t_multi(0, 0, 4, 3);
    t_multi(1, 2, 5, 2);
    t_rearm();
    t_rows();
    t_release();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule